// File: doc/BRIEF.md
# Capture/Compare Timer with PWM and One-Pulse Output

This block is a free-running up-counter with two match channels, two edge-capture channels and two waveform modes. The counter advances on ticks from a small prescaler (system clock divided by 2, 4 or 8) or from edges on an external clock pin, which is synchronized first. Each match channel compares the counter with a programmable value on every tick, raises a status flag and sets its waveform level. Each capture channel stores the counter value when the selected edge arrives on its pin.

Two modes reshape output 1. In PWM mode, match register 2 sets the period: the counter returns to zero on it, and match register 1 sets where the pulse ends. In one-pulse mode, an edge on capture pin 1 restarts the counter and starts a single pulse that ends at match register 1. The pin-enable bits only gate the waveforms onto the output pins, and a disabled pin is driven low. The matching, the flags and the waveform state keep running whatever the enables are.

Software reaches the block through a single-cycle write strobe and a combinational read port over eight word addresses.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, every register (mode, auxiliary, both match values, counter, both captures, flags) reads zero and both compare pins are low.
- R2: Mode register (address 0) bits [3:2] select the counter clock: 00 = system clock /4, 01 = /2, 10 = /8. The counter advances by one per tick and wraps from FFFFh to 0000h. The prescaler runs free from reset, so a /N tick falls on every cycle whose count since reset is N-1 mod N.
- R3: Clock select 11 counts edges on the external clock pin. Mode bit 0 picks the edge (1 rising, 0 falling). The pin passes two synchronizer flops and one history flop, and the counter moves on the third rising clock edge after the pin changes. With the external pin parameter at 0, this selection stops the counter.
- R4: On a tick with the counter equal to match 1 (address 2), flag bit 0 sets and waveform 1 takes auxiliary bit 1 as its level. On a tick with the counter equal to match 2 (address 3), flag bit 1 sets and waveform 2 takes auxiliary bit 2.
- R5: Mode bit 7 routes waveform 1 to compare pin 1, and mode bit 6 routes waveform 2 to compare pin 2. A pin with its enable clear is low, while its matches, flags and waveform state behave as in R4.
- R6: PWM mode (mode bit 4): a tick with the counter equal to match 2 reloads the counter to 0 and drives waveform 1 to auxiliary bit 2. A match-1 tick drives it to auxiliary bit 1, and the reload takes precedence.
- R7: One-pulse mode (mode bit 5 with bit 4 clear): the capture-1 edge selected by auxiliary bit 0 (1 rising, 0 falling) clears the counter and drives waveform 1 to auxiliary bit 2. A later match-1 tick returns it to auxiliary bit 1. No capture-1 value is latched in this mode.
- R8: Outside one-pulse mode, the capture-1 edge selected by auxiliary bit 0 latches the counter into capture 1 (address 4) and sets flag bit 2. The opposite edge does nothing.
- R9: The capture-2 edge selected by mode bit 1 (1 rising, 0 falling) latches the counter into capture 2 (address 5) and sets flag bit 3.
- R10: Writing the flag address (7) clears each flag whose data bit is 1. A flag set by an event in the same cycle stays set.
- R11: Addresses 0 mode, 1 auxiliary, 2 match 1, 3 match 2, 4 capture 1, 5 capture 2, 6 counter, 7 flags read back on the read port. A write to address 6 loads the counter and takes precedence over ticks and triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | W | Write data |
| regRdData | output | W | Read data of the addressed register |
| capPin1 | input | 1 | Capture 1 / one-pulse trigger pin |
| capPin2 | input | 1 | Capture 2 pin |
| extClkPin | input | 1 | External counter clock pin |
| cmpPin1 | output | 1 | Compare / PWM / pulse output 1 |
| cmpPin2 | output | 1 | Compare output 2 |
| statusFlags | output | 4 | {capture2, capture1, match2, match1} flags |

## Verification
On every cycle, the embedded assertions check the following: the counter holds when nothing moves it, a divided tick never comes on two cycles in a row, a match sets its flag, a capture latches the prior counter value, a PWM period match returns the counter to zero, and a flag clear takes effect. Other behaviours depend on sequences of events, and only the bench's scenarios show them: the pulse shape in PWM and one-pulse modes, the synchronizer latency on the external clock and capture pins, the rejection of the wrong edge polarity, the pins held low while the flags still rise, and the counter wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    CLK_DIV4 = 2'b00,
    CLK_DIV2 = 2'b01,
    CLK_DIV8 = 2'b10,
    CLK_EXT  = 2'b11
  } clkSel_e;

  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned FLAG_N   = 4;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_AUX  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP2 = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd7;

  typedef struct packed {
    logic              tick;
    logic              trig;
    logic              cap1Evt;
    logic              cap2Evt;
    logic              pwmMode;
    logic              olv1;
    logic              olv2;
    logic              cntLoad;
    logic [FLAG_N-1:0] flagClr;
  } strobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter bit          HAS_EXT_PIN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [W-1:0]      regWrData,
  input  logic              capPin1,
  input  logic              capPin2,
  input  logic              extClkPin,
  output logic [7:0]        modeReg,
  output logic [2:0]        auxReg,
  output logic [W-1:0]      cmp1Val,
  output logic [W-1:0]      cmp2Val,
  output strobe_t           st
);

  localparam int unsigned PIN_N  = 3;
  localparam int unsigned PRE_W  = 3;

  logic [PIN_N-1:0] pinsIn, syncA, syncB, pinHist, riseEdge, fallEdge;
  logic [PRE_W-1:0] presc;
  clkSel_e          clkSel;
  logic             extTick, divTick, cap1Edge, cap2Edge, opmActive;

  assign pinsIn = {extClkPin, capPin2, capPin1};

  generate
    for (genvar i = 0; i < PIN_N; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[i]   <= 1'b0;
          syncB[i]   <= 1'b0;
          pinHist[i] <= 1'b0;
        end else begin
          syncA[i]   <= pinsIn[i];
          syncB[i]   <= syncA[i];
          pinHist[i] <= syncB[i];
        end
      end
      assign riseEdge[i] = syncB[i] & ~pinHist[i];
      assign fallEdge[i] = ~syncB[i] & pinHist[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      auxReg  <= '0;
      cmp1Val <= '0;
      cmp2Val <= '0;
      presc   <= '0;
    end else begin
      presc <= presc + 1'b1;
      if (regWrEn) begin
        unique case (regAddr)
          A_MODE:  modeReg <= regWrData[7:0];
          A_AUX:   auxReg  <= regWrData[2:0];
          A_CMP1:  cmp1Val <= regWrData;
          A_CMP2:  cmp2Val <= regWrData;
          default: ;
        endcase
      end
    end
  end

  assign clkSel = clkSel_e'(modeReg[3:2]);

  generate
    if (HAS_EXT_PIN) begin : g_ext
      assign extTick = modeReg[0] ? riseEdge[2] : fallEdge[2];
    end else begin : g_noext
      assign extTick = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (clkSel)
      CLK_DIV2: divTick = presc[0];
      CLK_DIV4: divTick = &presc[1:0];
      CLK_DIV8: divTick = &presc;
      default:  divTick = extTick;
    endcase
  end

  assign cap1Edge  = auxReg[0]  ? riseEdge[0] : fallEdge[0];
  assign cap2Edge  = modeReg[1] ? riseEdge[1] : fallEdge[1];
  assign opmActive = modeReg[5] & ~modeReg[4];

  always_comb begin
    st         = '0;
    st.tick    = divTick;
    st.trig    = opmActive & cap1Edge;
    st.cap1Evt = ~opmActive & cap1Edge;
    st.cap2Evt = cap2Edge;
    st.pwmMode = modeReg[4];
    st.olv1    = auxReg[1];
    st.olv2    = auxReg[2];
    st.cntLoad = regWrEn && (regAddr == A_CNT);
    st.flagClr = (regWrEn && (regAddr == A_FLAG)) ? regWrData[FLAG_N-1:0] : '0;
  end

  // R2
  divided_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.tick && clkSel != CLK_EXT) |=> (!st.tick || clkSel == CLK_EXT));

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [W-1:0]      cmp1Val,
  input  logic [W-1:0]      cmp2Val,
  input  logic [W-1:0]      loadVal,
  output logic [W-1:0]      cnt,
  output logic [W-1:0]      cap1,
  output logic [W-1:0]      cap2,
  output logic [FLAG_N-1:0] flags,
  output logic              wave1,
  output logic              wave2
);

  logic match1, match2, reload;
  logic [FLAG_N-1:0] flagSet;

  assign match1  = st.tick && (cnt == cmp1Val);
  assign match2  = st.tick && (cnt == cmp2Val);
  assign reload  = st.pwmMode && match2;
  assign flagSet = {st.cap2Evt, st.cap1Evt, match2, match1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      cap1  <= '0;
      cap2  <= '0;
      flags <= '0;
      wave1 <= 1'b0;
      wave2 <= 1'b0;
    end else begin
      if (st.cntLoad)      cnt <= loadVal;
      else if (st.trig)    cnt <= '0;
      else if (st.tick)    cnt <= reload ? '0 : cnt + 1'b1;

      if (st.cap1Evt) cap1 <= cnt;
      if (st.cap2Evt) cap2 <= cnt;

      flags <= (flags & ~st.flagClr) | flagSet;

      if (st.pwmMode) begin
        if (reload)       wave1 <= st.olv2;
        else if (match1)  wave1 <= st.olv1;
      end else begin
        if (st.trig)      wave1 <= st.olv2;
        else if (match1)  wave1 <= st.olv1;
      end

      if (match2) wave2 <= st.olv2;
    end
  end

  // R2
  counter_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !st.trig && !st.cntLoad) |=> cnt == $past(cnt));
  // R4
  match_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.tick && cnt == cmp1Val) |=> flags[0]);
  // R6
  pwm_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.pwmMode && st.tick && cnt == cmp2Val && !st.cntLoad && !st.trig) |=> cnt == '0);
  // R8
  capture_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.cap1Evt |=> (cap1 == $past(cnt)) && flags[2]);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.flagClr[3] && !st.cap2Evt) |=> !flags[3]);

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import timer_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter bit          HAS_EXT_PIN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      regRdData,
  input  logic              capPin1,
  input  logic              capPin2,
  input  logic              extClkPin,
  output logic              cmpPin1,
  output logic              cmpPin2,
  output logic [3:0]        statusFlags
);

  logic [7:0]        modeReg;
  logic [2:0]        auxReg;
  logic [W-1:0]      cmp1Val, cmp2Val, cnt, cap1, cap2;
  logic [FLAG_N-1:0] flags;
  logic              wave1, wave2;
  strobe_t           st;

  timer_ctrl #(.W(W), .HAS_EXT_PIN(HAS_EXT_PIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .capPin1(capPin1), .capPin2(capPin2),
    .extClkPin(extClkPin), .modeReg(modeReg), .auxReg(auxReg),
    .cmp1Val(cmp1Val), .cmp2Val(cmp2Val), .st(st)
  );

  timer_datapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .cmp1Val(cmp1Val), .cmp2Val(cmp2Val),
    .loadVal(regWrData), .cnt(cnt), .cap1(cap1), .cap2(cap2),
    .flags(flags), .wave1(wave1), .wave2(wave2)
  );

  assign cmpPin1     = modeReg[7] & wave1;
  assign cmpPin2     = modeReg[6] & wave2;
  assign statusFlags = flags;

  always_comb begin
    unique case (regAddr)
      A_MODE:  regRdData = W'(modeReg);
      A_AUX:   regRdData = W'(auxReg);
      A_CMP1:  regRdData = cmp1Val;
      A_CMP2:  regRdData = cmp2Val;
      A_CAP1:  regRdData = cap1;
      A_CAP2:  regRdData = cap2;
      A_CNT:   regRdData = cnt;
      default: regRdData = W'(flags);
    endcase
  end

endmodule

// File: tb/capcmp_timer_tb_top.sv
module capcmp_timer_tb_top;

  localparam int W = 16;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = 3'd6;
  logic [W-1:0]  regWrData = '0;
  logic [W-1:0]  regRdData;
  logic          capPin1 = 1'b0, capPin2 = 1'b0, extClkPin = 1'b0;
  logic          cmpPin1, cmpPin2;
  logic [3:0]    statusFlags;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int rdSel = 6;
  bit checking = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;

  capcmp_timer #(.W(W), .HAS_EXT_PIN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .capPin1(capPin1),
    .capPin2(capPin2), .extClkPin(extClkPin), .cmpPin1(cmpPin1),
    .cmpPin2(cmpPin2), .statusFlags(statusFlags)
  );

  // Behavioural reference model
  int mMode = 0, mAux = 0, mCmp1 = 0, mCmp2 = 0, mCnt = 0;
  int mCap1 = 0, mCap2 = 0, mFlags = 0, mW1 = 0, mW2 = 0, mCycle = 0;
  int pinHist[3][$];   // per pin: history of sampled values, newest first

  function automatic int edgeOf(int p, int rising);
    if (pinHist[p].size() < 3) return 0;
    if (rising != 0) return (pinHist[p][1] == 1 && pinHist[p][2] == 0) ? 1 : 0;
    return (pinHist[p][1] == 0 && pinHist[p][2] == 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mAux = 0; mCmp1 = 0; mCmp2 = 0; mCnt = 0; mCap1 = 0;
      mCap2 = 0; mFlags = 0; mW1 = 0; mW2 = 0; mCycle = 0;
      for (int p = 0; p < 3; p++) pinHist[p] = {0, 0, 0};
    end else begin
      int sel, tick, pwm, opm, c1, c2, trig, m1, m2, rel, clr;
      int nCnt, nW1, nW2;
      sel = (mMode >> 2) & 3;
      case (sel)
        0: tick = (mCycle % 4 == 3);
        1: tick = (mCycle % 2 == 1);
        2: tick = (mCycle % 8 == 7);
        default: tick = edgeOf(2, mMode & 1);
      endcase
      pwm  = (mMode >> 4) & 1;
      opm  = ((mMode >> 5) & 1) && !pwm;
      c1   = edgeOf(0, mAux & 1);
      c2   = edgeOf(1, (mMode >> 1) & 1);
      trig = opm && c1;
      m1   = tick && (mCnt == mCmp1);
      m2   = tick && (mCnt == mCmp2);
      rel  = pwm && m2;
      nCnt = mCnt;
      if (regWrEn && regAddr == 6) nCnt = regWrData;
      else if (trig) nCnt = 0;
      else if (tick) nCnt = rel ? 0 : (mCnt + 1) % 65536;
      nW1 = mW1;
      if (pwm) begin
        if (rel) nW1 = (mAux >> 2) & 1; else if (m1) nW1 = (mAux >> 1) & 1;
      end else begin
        if (trig) nW1 = (mAux >> 2) & 1; else if (m1) nW1 = (mAux >> 1) & 1;
      end
      nW2 = m2 ? ((mAux >> 2) & 1) : mW2;
      if (c1 && !opm) mCap1 = mCnt;
      if (c2) mCap2 = mCnt;
      clr = (regWrEn && regAddr == 7) ? (regWrData & 15) : 0;
      mFlags = (mFlags & ~clr) | (m1 ? 1 : 0) | (m2 ? 2 : 0)
               | ((c1 && !opm) ? 4 : 0) | (c2 ? 8 : 0);
      if (regWrEn) begin
        case (regAddr)
          0: mMode = regWrData & 255;
          1: mAux  = regWrData & 7;
          2: mCmp1 = regWrData;
          3: mCmp2 = regWrData;
          default: ;
        endcase
      end
      mCnt = nCnt; mW1 = nW1; mW2 = nW2;
      mCycle = mCycle + 1;
      pinHist[0].push_front(int'(capPin1));
      pinHist[1].push_front(int'(capPin2));
      pinHist[2].push_front(int'(extClkPin));
      for (int p = 0; p < 3; p++) if (pinHist[p].size() > 3) void'(pinHist[p].pop_back());
    end
  end

  function automatic int expRead(int a);
    case (a)
      0: return mMode;
      1: return mAux;
      2: return mCmp1;
      3: return mCmp2;
      4: return mCap1;
      5: return mCap2;
      6: return mCnt;
      default: return mFlags;
    endcase
  endfunction

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", curReq, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("cmpPin1", int'(cmpPin1), (((mMode >> 7) & 1) != 0) ? mW1 : 0);
      chk("cmpPin2", int'(cmpPin2), (((mMode >> 6) & 1) != 0) ? mW2 : 0);
      chk("statusFlags", int'(statusFlags), mFlags);
      chk("regRdData", int'(regRdData), expRead(int'(regAddr)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = W'(d);
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 3'(rdSel);
  endtask

  task automatic setRd(int a);
    rdSel = a;
    @(posedge clk); #1;
    regAddr = 3'(a);
  endtask

  initial begin
    // R1: reset values
    idle(1);
    checking = 1'b1;
    curReq = "R1";
    idle(5);
    chk("reset counter", int'(regRdData), 0);
    @(posedge clk); #1 rstN = 1'b1;

    // R2: divided clocks and wrap
    curReq = "R2";
    idle(40);
    wr(0, 'h04); idle(40);
    wr(0, 'h08); idle(64);
    wr(0, 'h04); wr(6, 'hFFF0); idle(50);

    // R4: compare matches with both levels
    curReq = "R4";
    wr(2, 'h20); wr(3, 'h30); wr(1, 6); wr(0, 'hC4); wr(6, 'h18); idle(100);
    wr(1, 0); wr(6, 'h18); idle(100);

    // R5: pins disabled, flags still set
    curReq = "R5";
    setRd(7);
    wr(7, 15); wr(0, 'h04); wr(1, 6); wr(6, 'h18); idle(100);

    // R10: flag clear
    curReq = "R10";
    wr(7, 'h1); idle(3); wr(7, 'hE); idle(3);

    // R8: capture 1 polarity
    curReq = "R8";
    setRd(4);
    wr(1, 1);
    idle(5); capPin1 = 1'b1; idle(10); capPin1 = 1'b0; idle(10);
    wr(1, 0);
    idle(7); capPin1 = 1'b1; idle(10); capPin1 = 1'b0; idle(10);

    // R9: capture 2 polarity
    curReq = "R9";
    setRd(5);
    wr(0, 'h06);
    idle(3); capPin2 = 1'b1; idle(9); capPin2 = 1'b0; idle(9);
    wr(0, 'h04);
    idle(6); capPin2 = 1'b1; idle(9); capPin2 = 1'b0; idle(9);

    // R3: external clock both edges
    curReq = "R3";
    setRd(6);
    wr(0, 'h0D);
    for (int i = 0; i < 20; i++) begin extClkPin = ~extClkPin; idle(3); end
    wr(0, 'h0C);
    for (int i = 0; i < 20; i++) begin extClkPin = ~extClkPin; idle(4); end

    // R6: PWM
    curReq = "R6";
    wr(2, 3); wr(3, 9); wr(1, 4); wr(6, 0); wr(0, 'h94); idle(200);
    wr(1, 2); idle(100);

    // R7: one-pulse, both trigger polarities
    curReq = "R7";
    setRd(4);
    wr(0, 0); wr(2, 6); wr(1, 5); wr(0, 'hA4); idle(20);
    capPin1 = 1'b1; idle(40); capPin1 = 1'b0; idle(40);
    wr(1, 4); idle(10);
    capPin1 = 1'b1; idle(40); capPin1 = 1'b0; idle(60);

    // R11: readback of every address
    curReq = "R11";
    wr(6, 'h1234);
    for (int a = 0; a < 8; a++) begin setRd(a); idle(3); end

    checking = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule